// File: doc/BRIEF.md
# USB Data Packet CRC16 Residue Checker

This block decides whether a received USB data packet arrived intact. A byte-level receiver presents the packet payload one byte per strobe, followed by the two CRC bytes that travel with the packet, least significant byte first. The checker folds every byte into a 16-bit CRC register. The register uses the reflected generator 0xA001 and shifts right, so the least significant bit is processed first. When the packet closes, the register is compared against the fixed remainder that a clean packet always leaves. The checker never needs to extract or compare the transmitted CRC value.

A start-of-packet pulse reloads the register at any time. An end-of-packet pulse produces a one-cycle verdict on the following clock. A build parameter chooses between two arrangements. In the first, each byte updates the register on its own strobe. In the second, the update runs one byte behind the data. That arrangement starts from a preload that already absorbs a virtual zero byte, and it finishes the last pending byte combinationally when the packet ends. Both arrangements give the same verdicts.

Top module: `usb_crc16_chk`

## Requirements
- R1: A packet is judged good when its payload bytes are followed by the one's complement of the CRC, sent low byte first. That CRC is computed LSB first with the reflected constant 0xA001 and a start value of 0xFFFF. For a good packet, the register after the last byte must equal 0xB001, and crc_ok_o then reads 1.
- R2: If any single bit of the payload or of the CRC bytes is altered, crc_ok_o stays 0 for that packet.
- R3: crc_ok_o can be 1 only on the cycle right after a cycle with eop_i high, and it is high for that single cycle. A second eop_i with no bytes in between reads 0.
- R4: crc_ok_o stays 0 if fewer than MIN_BYTES (default 2) bytes were accepted since the last sop_i, the last eop_i or reset. This includes eop_i arriving with no sop_i at all.
- R5: sop_i reloads the register and clears the byte count whatever came before it. Bytes taken in before the restart have no effect on the next verdict.
- R6: A byte strobe in the same cycle as sop_i is discarded.
- R7: A byte strobe in the same cycle as eop_i is discarded. The verdict covers only bytes accepted on earlier cycles.
- R8: Idle cycles between byte strobes do not change the verdict.
- R9: With DEFER_UPDATE=1, the register is preloaded with 0xFE54 and a zero byte is treated as pending. That mode gives the same crc_ok_o as DEFER_UPDATE=0 for every stimulus, including the completion of the last pending byte at eop_i.
- R10: While reset is held, and on the first cycles after it, crc_ok_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sop_i | input | 1 | Start of packet: reload register, clear count |
| byte_vld_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Received byte |
| eop_i | input | 1 | End of packet: request a verdict |
| crc_ok_o | output | 1 | One-cycle good-packet flag |

## Verification
The verdict is registered once: the rising edge that captures eop_i also loads crc_ok_o. The result is therefore due exactly one clock after the eop_i cycle. On every other cycle, crc_ok_o must be low. The monitor records eop_i at each rising edge and reads both checker variants at the following falling edge. At that point it pops the expected verdict that the driver queued when it raised eop_i, and on all remaining cycles it expects a low output. Expected verdicts come from a bit-serial CRC model in the bench and from the byte-count and priority rules.

// File: rtl/usb_crc16_pkg.sv
package usb_crc16_pkg;
    localparam int CRC_W  = 16;
    localparam int BYTE_W = 8;

    localparam logic [CRC_W-1:0] POLY_REFL    = 16'hA001;
    localparam logic [CRC_W-1:0] SEED_DIRECT  = 16'hFFFF;
    localparam logic [CRC_W-1:0] SEED_DEFER   = 16'hFE54;
    localparam logic [CRC_W-1:0] GOOD_RESIDUE = 16'hB001;

    typedef struct packed {
        logic [CRC_W-1:0]  crc;
        logic [BYTE_W-1:0] pend;
        logic              ok;
    } chk_state_t;
endpackage

// File: rtl/crc16_byte_step.sv
module crc16_byte_step #(
    parameter int                 CRC_W  = 16,
    parameter int                 BYTE_W = 8,
    parameter logic [CRC_W-1:0]   POLY   = 16'hA001
) (
    input  logic [CRC_W-1:0]  crc_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic [CRC_W-1:0]  crc_o
);
    localparam int PAD_W = CRC_W - BYTE_W;

    logic [CRC_W-1:0] stage [BYTE_W+1];

    assign stage[0] = crc_i ^ {{PAD_W{1'b0}}, data_i};

    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        assign stage[i+1] = (stage[i] >> 1) ^ (stage[i][0] ? POLY : '0);
    end

    assign crc_o = stage[BYTE_W];
endmodule

// File: rtl/rx_byte_counter.sv
module rx_byte_counter #(
    parameter int MIN_BYTES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sop_i,
    input  logic eop_i,
    input  logic byte_vld_i,
    output logic enough_o
);
    localparam int                CNT_W   = $clog2(MIN_BYTES + 1);
    localparam logic [CNT_W-1:0]  CNT_MAX = CNT_W'(MIN_BYTES);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (sop_i || eop_i) begin
            cnt_d = '0;
        end else if (byte_vld_i && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign enough_o = (cnt_q == CNT_MAX);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);                                          // R4
    AST_SOP_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        sop_i |=> (cnt_q == '0));                                   // R5
    AST_EOP_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        eop_i |=> !enough_o);                                       // R3
endmodule

// File: rtl/usb_crc16_chk.sv
module usb_crc16_chk #(
    parameter bit DEFER_UPDATE = 1'b1,
    parameter int MIN_BYTES    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sop_i,
    input  logic       byte_vld_i,
    input  logic [7:0] byte_i,
    input  logic       eop_i,
    output logic       crc_ok_o
);
    import usb_crc16_pkg::*;

    localparam logic [CRC_W-1:0] SEED = DEFER_UPDATE ? SEED_DEFER : SEED_DIRECT;

    chk_state_t        st_d, st_q;
    logic [CRC_W-1:0]  step_crc;
    logic [BYTE_W-1:0] step_data;
    logic [CRC_W-1:0]  final_crc;
    logic              enough;

    if (DEFER_UPDATE) begin : g_defer
        assign step_data = st_q.pend;
        assign final_crc = step_crc;
    end else begin : g_direct
        assign step_data = byte_i;
        assign final_crc = st_q.crc;
    end

    crc16_byte_step #(
        .CRC_W (CRC_W),
        .BYTE_W(BYTE_W),
        .POLY  (POLY_REFL)
    ) u_step (
        .crc_i (st_q.crc),
        .data_i(step_data),
        .crc_o (step_crc)
    );

    rx_byte_counter #(
        .MIN_BYTES(MIN_BYTES)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .sop_i     (sop_i),
        .eop_i     (eop_i),
        .byte_vld_i(byte_vld_i),
        .enough_o  (enough)
    );

    always_comb begin
        st_d    = st_q;
        st_d.ok = 1'b0;
        if (sop_i) begin
            st_d.crc  = SEED;
            st_d.pend = '0;
        end else if (eop_i) begin
            st_d.ok = enough && (final_crc == GOOD_RESIDUE);
        end else if (byte_vld_i) begin
            st_d.crc  = step_crc;
            st_d.pend = byte_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.crc  <= SEED;
            st_q.pend <= '0;
            st_q.ok   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign crc_ok_o = st_q.ok;

    AST_OK_ONLY_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        crc_ok_o |-> $past(eop_i));                                 // R3
    AST_OK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        crc_ok_o |=> !crc_ok_o);                                    // R3
    AST_OK_NEEDS_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        (eop_i && !enough) |=> !crc_ok_o);                          // R4
    AST_SOP_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        sop_i |=> (st_q.crc == SEED) && !crc_ok_o);                 // R5
    AST_IDLE_HOLDS_CRC: assert property (@(posedge clk) disable iff (!rst_n)
        (!sop_i && !byte_vld_i) |=> $stable(st_q.crc));             // R8
endmodule

// File: tb/usb_crc16_chk_bench.sv
module usb_crc16_chk_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sop = 1'b0, vld = 1'b0, eop = 1'b0;
    logic [7:0] dat = 8'h00;
    logic       ok_defer, ok_direct;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    bit    exp_q[$];
    string tag_q[$];
    logic  eop_seen = 1'b0;

    always #10 clk = ~clk;

    usb_crc16_chk #(.DEFER_UPDATE(1'b1)) u_usb_crc16_chk (
        .clk(clk), .rst_n(rst_n), .sop_i(sop), .byte_vld_i(vld),
        .byte_i(dat), .eop_i(eop), .crc_ok_o(ok_defer));

    usb_crc16_chk #(.DEFER_UPDATE(1'b0)) u_usb_crc16_chk_direct (
        .clk(clk), .rst_n(rst_n), .sop_i(sop), .byte_vld_i(vld),
        .byte_i(dat), .eop_i(eop), .crc_ok_o(ok_direct));

    function automatic logic [15:0] ref_crc(input logic [7:0] b[$]);
        logic [15:0] c = 16'hFFFF;
        foreach (b[k]) begin
            for (int j = 0; j < 8; j++) begin
                if (c[0] ^ b[k][j]) c = (c >> 1) ^ 16'hA001;
                else                c = c >> 1;
            end
        end
        return c;
    endfunction

    task automatic put(input bit s, input bit v, input logic [7:0] b, input bit e);
        @(negedge clk);
        sop = s; vld = v; dat = b; eop = e;
    endtask

    task automatic expect_verdict(input bit exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic add_crc(ref logic [7:0] p[$]);
        logic [15:0] c = ~ref_crc(p);
        p.push_back(c[7:0]);
        p.push_back(c[15:8]);
    endtask

    task automatic send_bytes(input logic [7:0] p[$], input int gap);
        foreach (p[k]) begin
            put(1'b0, 1'b1, p[k], 1'b0);
            for (int g = 0; g < gap; g++) put(1'b0, 1'b0, 8'h00, 1'b0);
        end
    endtask

    task automatic close(input bit exp, input string tag);
        put(1'b0, 1'b0, 8'h00, 1'b1);
        expect_verdict(exp, tag);
        put(1'b0, 1'b0, 8'h00, 1'b0);
        put(1'b0, 1'b0, 8'h00, 1'b0);
    endtask

    always @(posedge clk) eop_seen <= eop;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit    e;
            string t;
            if (eop_seen) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
            end else begin
                e = 1'b0;
                t = "R3 idle";
            end
            n_vec++;
            if (ok_defer !== e) begin
                n_fail++;
                $display("FAIL %s deferred: crc_ok=%b expected %b", t, ok_defer, e);
            end
            n_vec++;
            if (ok_direct !== e) begin
                n_fail++;
                $display("FAIL %s/R9 direct: crc_ok=%b expected %b", t, ok_direct, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] p[$];
        logic [7:0] x;

        // R10: output low during reset
        repeat (3) @(negedge clk);
        n_vec++;
        if (ok_defer !== 1'b0 || ok_direct !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 reset: crc_ok=%b/%b expected 0", ok_defer, ok_direct);
        end
        rst_n = 1'b1;
        put(1'b0, 1'b0, 8'h00, 1'b0);

        // R4: eop with no sop and no bytes
        close(1'b0, "R4 eop without packet");

        // R1: short good packet
        p = '{8'h12, 8'h34}; add_crc(p);
        put(1'b1, 1'b0, 8'h00, 1'b0); send_bytes(p, 0);
        close(1'b1, "R1 good two-byte payload");

        // R3: second eop with no bytes
        close(1'b0, "R3 repeated eop");

        // R1/R4: empty payload, CRC bytes 00 00 only
        p = '{}; add_crc(p);
        put(1'b1, 1'b0, 8'h00, 1'b0); send_bytes(p, 0);
        close(1'b1, "R1 empty payload boundary");

        // R4: one byte only
        p = '{8'h00};
        put(1'b1, 1'b0, 8'h00, 1'b0); send_bytes(p, 0);
        close(1'b0, "R4 single byte");

        // R2: corrupted payload bit
        p = '{8'hC3, 8'h5A, 8'h01}; add_crc(p); p[1] = p[1] ^ 8'h10;
        put(1'b1, 1'b0, 8'h00, 1'b0); send_bytes(p, 0);
        close(1'b0, "R2 corrupted payload");

        // R2: corrupted CRC byte
        p = '{8'hC3, 8'h5A, 8'h01}; add_crc(p); p[4] = p[4] ^ 8'h80;
        put(1'b1, 1'b0, 8'h00, 1'b0); send_bytes(p, 0);
        close(1'b0, "R2 corrupted crc byte");

        // R5: restart mid-packet
        put(1'b1, 1'b0, 8'h00, 1'b0);
        send_bytes('{8'hDE, 8'hAD, 8'hBE}, 0);
        p = '{8'h31, 8'h32, 8'h33}; add_crc(p);
        put(1'b1, 1'b0, 8'h00, 1'b0); send_bytes(p, 0);
        close(1'b1, "R5 restart discards earlier bytes");

        // R6: byte in sop cycle dropped
        p = '{8'hA0, 8'h0B}; add_crc(p);
        put(1'b1, 1'b1, 8'h77, 1'b0); send_bytes(p, 0);
        close(1'b1, "R6 byte with sop ignored");

        // R8: gaps between strobes
        p = '{8'h01, 8'h80, 8'hFF, 8'h00}; add_crc(p);
        put(1'b1, 1'b0, 8'h00, 1'b0); send_bytes(p, 3);
        close(1'b1, "R8 gapped strobes");

        // R7: byte in eop cycle dropped
        p = '{8'h55, 8'hAA}; add_crc(p);
        put(1'b1, 1'b0, 8'h00, 1'b0); send_bytes(p, 0);
        put(1'b0, 1'b1, 8'hA5, 1'b1);
        expect_verdict(1'b1, "R7 byte with eop ignored");
        put(1'b0, 1'b0, 8'h00, 1'b0);
        put(1'b0, 1'b0, 8'h00, 1'b0);

        // R1/R9: long pseudo-random packet
        p = '{}; x = 8'h3C;
        for (int k = 0; k < 64; k++) begin
            x = x * 8'd5 + 8'd1;
            p.push_back(x);
        end
        add_crc(p);
        put(1'b1, 1'b0, 8'h00, 1'b0); send_bytes(p, 0);
        close(1'b1, "R1 long packet");

        // R2/R9: long packet, last CRC bit flipped
        p[p.size()-1] = p[p.size()-1] ^ 8'h01;
        put(1'b1, 1'b0, 8'h00, 1'b0); send_bytes(p, 0);
        close(1'b0, "R2 long packet corrupted");

        repeat (3) put(1'b0, 1'b0, 8'h00, 1'b0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule